// File: doc/BRIEF.md
# Stack Word Memory with Edge-Loaded Output Register

This block is a small read/write memory of 16 four-bit words. A separate output register sits in front of the data outputs. It is meant for register-stack use: a value can be pushed into the memory while the previously read value stays on the outputs. A single strobe input paces the block. While the strobe is low, chip select and write enable are both low, the addressed word is written. When the strobe rises with chip select low, the output register is loaded. It takes the addressed word on a read, or the incoming data on a write, so new data passes straight through.

The block runs on a free-running system clock. All strobe and control inputs are sampled into an input stage on that clock. A strobe rising edge is found when the sampled strobe is high and was low on the previous sample. The output register loads on the next system-clock edge after that. The outputs model a three-state bus in the usual way: there is a per-bit drive-enable, and the data value is forced to zero whenever the outputs are disabled. Memory contents are undefined after reset.

Top module: `stack_ram_oreg`

## Requirements
- R1: With `rst` high at a clock edge, the output register clears to 0 and the strobe edge detector is cleared. With `oe_n` low after reset, `q` reads 0.
- R2: When the sampled `stb`, `cs_n` and `we_n` are all low, `din` is written into the word at `addr`. The write lands two clock edges after the inputs are applied.
- R3: During one write window, the addressed word follows every change of `din`. The last value present before the window closes is the one kept.
- R4: On a sampled strobe rising edge with `cs_n` low and `we_n` high, the output register loads the addressed word. `q` shows it after the second clock edge following the strobe change.
- R5: On a sampled strobe rising edge with `cs_n` low and `we_n` low, the output register loads `din` directly.
- R6: The output register does not change while memory writes take place with the strobe low.
- R7: With `oe_n` high, `q_drv` is all zeros and `q` is 0. With `oe_n` low, `q_drv` is all ones and `q` equals the output register.
- R8: With `cs_n` high, no memory write occurs, and a strobe rising edge leaves the output register unchanged.
- R9: A write in the strobe-low phase, followed directly by a read rising edge to the same address, returns the newly written word.
- R10: A strobe held high loads the output register only once. Later changes of `addr` or `din` do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stb | input | 1 | Clock-pulse strobe: low phase enables writes, rising edge loads the output register |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (4) | Word address |
| din | input | DATA_W (4) | Write data |
| q | output | DATA_W (4) | Output register value, zero when disabled |
| q_drv | output | DATA_W (4) | Per-bit drive-enable, high when driving |

## Verification
The bench builds the block with the default widths: a 4-bit address and 4-bit words, so 16 locations. At that size every word can be written with a distinct pattern and read back. Aliasing between addresses and stuck data bits therefore show up as wrong read values. The small depth also keeps the strobe edge, pass-through, hold and chip-deselect corner cases within a few hundred cycles.

// File: rtl/stkram_pkg.sv
package stkram_pkg;

    localparam int ADDR_W_DEF = 4;
    localparam int DATA_W_DEF = 4;

    typedef struct packed {
        logic stb;
        logic cs_n;
        logic we_n;
    } ctrl_t;

    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_MEM  = 2'd1,
        LD_DIN  = 2'd2
    } load_sel_e;

    function automatic logic is_write(input ctrl_t c);
        return (!c.stb) && (!c.cs_n) && (!c.we_n);
    endfunction

    function automatic load_sel_e pick_load(input logic rise, input ctrl_t c);
        if (!rise || c.cs_n) return LD_NONE;
        if (c.we_n)          return LD_MEM;
        return LD_DIN;
    endfunction

endpackage

// File: rtl/stkram_sample.sv
module stkram_sample
    import stkram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output ctrl_t             ctrl_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q,
    output logic              rise
);

    logic stb_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '{stb: 1'b0, cs_n: 1'b1, we_n: 1'b1};
            stb_prev <= 1'b0;
            addr_q   <= '0;
            din_q    <= '0;
        end else begin
            ctrl_q   <= '{stb: stb, cs_n: cs_n, we_n: we_n};
            stb_prev <= ctrl_q.stb;
            addr_q   <= addr;
            din_q    <= din;
        end
    end

    assign rise = ctrl_q.stb && !stb_prev;

    // R10: a rising edge is a single-cycle event
    a_r10_single_rise: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/stkram_array.sv
module stkram_array
    import stkram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  ctrl_t             ctrl_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] din_q,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];
    logic              wr_go;

    assign wr_go = is_write(ctrl_q);

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_go && (addr_q == ADDR_W'(i)))
                words[i] <= din_q;
        end
    end

    assign rdata = words[addr_q];

endmodule

// File: rtl/stkram_oreg.sv
module stkram_oreg
    import stkram_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  ctrl_t             ctrl_q,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] din_q,
    output logic [DATA_W-1:0] oreg
);

    load_sel_e sel;

    assign sel = pick_load(rise, ctrl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            oreg <= '0;
        end else begin
            unique case (sel)
                LD_MEM:  oreg <= rdata;
                LD_DIN:  oreg <= din_q;
                default: oreg <= oreg;
            endcase
        end
    end

    // R1: reset clears the register
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (oreg == '0));
    // R6: without a strobe edge the register holds
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(oreg));
    // R4: read edge captures the memory word
    a_r4_read_load: assert property (@(posedge clk) disable iff (rst)
        (rise && !ctrl_q.cs_n && ctrl_q.we_n) |=> (oreg == $past(rdata)));
    // R5: write edge passes data through
    a_r5_pass_load: assert property (@(posedge clk) disable iff (rst)
        (rise && !ctrl_q.cs_n && !ctrl_q.we_n) |=> (oreg == $past(din_q)));
    // R8: deselected edge leaves the register alone
    a_r8_deselect_hold: assert property (@(posedge clk) disable iff (rst)
        (rise && ctrl_q.cs_n) |=> $stable(oreg));

endmodule

// File: rtl/stack_ram_oreg.sv
module stack_ram_oreg
    import stkram_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q,
    output logic [DATA_W-1:0] q_drv
);

    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic              rise;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] oreg;

    stkram_sample #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sample (
        .clk(clk), .rst(rst), .stb(stb), .cs_n(cs_n), .we_n(we_n),
        .addr(addr), .din(din),
        .ctrl_q(ctrl_q), .addr_q(addr_q), .din_q(din_q), .rise(rise)
    );

    stkram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .ctrl_q(ctrl_q), .addr_q(addr_q), .din_q(din_q),
        .rdata(rdata)
    );

    stkram_oreg #(.DATA_W(DATA_W)) u_oreg (
        .clk(clk), .rst(rst), .rise(rise), .ctrl_q(ctrl_q),
        .rdata(rdata), .din_q(din_q), .oreg(oreg)
    );

    for (genvar b = 0; b < DATA_W; b++) begin : g_pin
        assign q_drv[b] = !oe_n;
        assign q[b]     = oe_n ? 1'b0 : oreg[b];
    end

    // R7: a disabled bus carries no value
    a_r7_off_zero: assert property (@(posedge clk) disable iff (rst)
        (q_drv == '0) |-> (q == '0));

endmodule

// File: tb/tb_stack_ram_oreg.sv
module tb_stack_ram_oreg;

    localparam int AW = 4;
    localparam int DW = 4;
    localparam int NV = 13;

    // vector: kind[13:12] (0 write, 1 read, 2 pass), addr[11:8], data[7:4], exp[3:0]
    localparam logic [13:0] VEC [NV] = '{
        {2'd1, 4'h0, 4'h0, 4'h1},
        {2'd1, 4'h5, 4'h0, 4'h0},
        {2'd1, 4'hF, 4'h0, 4'hE},
        {2'd0, 4'h3, 4'hA, 4'h0},
        {2'd1, 4'h3, 4'h0, 4'hA},
        {2'd2, 4'h7, 4'h6, 4'h6},
        {2'd1, 4'h7, 4'h0, 4'h6},
        {2'd1, 4'h1, 4'h0, 4'h4},
        {2'd0, 4'h1, 4'h0, 4'h0},
        {2'd1, 4'h1, 4'h0, 4'h0},
        {2'd2, 4'h2, 4'hF, 4'hF},
        {2'd1, 4'h2, 4'h0, 4'hF},
        {2'd1, 4'h4, 4'h0, 4'hD}
    };

    logic clk = 1'b0;
    logic rst, stb, cs_n, we_n, oe_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] q, q_drv;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    stack_ram_oreg #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .stb(stb), .cs_n(cs_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .q(q), .q_drv(q_drv)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        stb = 0; cs_n = 0; we_n = 0; addr = a; din = d;
        tick(2);
        cs_n = 1; we_n = 1;
        tick(1);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e,
                           input string req);
        stb = 0; cs_n = 0; we_n = 1; addr = a;
        tick(1);
        stb = 1;
        tick(2);
        check(req, q, e);
        stb = 0; cs_n = 1;
        tick(1);
    endtask

    task automatic do_pass(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [DW-1:0] e);
        stb = 0; cs_n = 0; we_n = 0; addr = a; din = d;
        tick(1);
        stb = 1;
        tick(2);
        check("R5", q, e);
        stb = 0; cs_n = 1; we_n = 1;
        tick(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        rst = 1; stb = 0; cs_n = 1; we_n = 1; oe_n = 1; addr = '0; din = '0;
        tick(3);
        rst = 0;
        tick(1);
        // R1 / R7: reset state, disabled then enabled
        check("R7", q_drv, 4'h0);
        check("R7", q, 4'h0);
        oe_n = 0;
        @(negedge clk);
        check("R7", q_drv, 4'hF);
        check("R1", q, 4'h0);

        // R2: fill every word
        for (int a = 0; a < 16; a++) do_write(AW'(a), DW'(a * 3 + 1));
        check("R6", q, 4'h0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][13:12])
                2'd0: do_write(VEC[i][11:8], VEC[i][7:4]);
                2'd1: do_read(VEC[i][11:8], VEC[i][3:0], "R4");
                default: do_pass(VEC[i][11:8], VEC[i][7:4], VEC[i][3:0]);
            endcase
        end

        // R3: data follows during one write window
        stb = 0; cs_n = 0; we_n = 0; addr = 4'h9; din = 4'h1;
        tick(1); din = 4'h2;
        tick(1); din = 4'h5;
        tick(2); cs_n = 1; we_n = 1;
        tick(1);
        do_read(4'h9, 4'h5, "R3");

        // R6: output holds while another word is written
        held = q;
        stb = 0; cs_n = 0; we_n = 0; addr = 4'hA; din = 4'h3;
        tick(1); check("R6", q, held);
        tick(1); check("R6", q, held);
        cs_n = 1; we_n = 1;
        tick(1); check("R6", q, held);
        do_read(4'hA, 4'h3, "R2");

        // R8: deselected write and edge have no effect
        stb = 0; cs_n = 1; we_n = 0; addr = 4'h0; din = 4'hB;
        tick(2);
        stb = 1;
        tick(3);
        check("R8", q, 4'h3);
        stb = 0; we_n = 1;
        tick(1);
        do_read(4'h0, 4'h1, "R8");

        // R7: disable and re-enable
        oe_n = 1;
        @(negedge clk);
        check("R7", q, 4'h0);
        check("R7", q_drv, 4'h0);
        oe_n = 0;
        @(negedge clk);
        check("R7", q, 4'h1);

        // R9: write then immediate read edge, same address
        stb = 0; cs_n = 0; we_n = 0; addr = 4'hB; din = 4'hC;
        tick(1);
        we_n = 1; stb = 1;
        tick(2);
        check("R9", q, 4'hC);

        // R10: strobe stays high; no reload on address change
        addr = 4'h2; din = 4'h7;
        tick(3);
        check("R10", q, 4'hC);
        we_n = 0;
        tick(3);
        check("R10", q, 4'hC);
        stb = 0; cs_n = 1; we_n = 1;
        tick(2);

        // R1: reset mid-run clears the register
        rst = 1;
        tick(1);
        rst = 0;
        tick(1);
        check("R1", q, 4'h0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule